// File: doc/BRIEF.md
# Busy-Indicating SAR ADC Host Controller

This block is the host-side sequencer for a 16-bit successive-approximation converter. The converter shares one data line for its busy indication and its serial result. On a user start request the controller raises the conversion-start line (`cnv`) for a fixed number of clocks and then drops it. It then watches the converter's data output. That line is pulled up and stays high while the conversion runs. When the converter pulls it low, the result is ready.

Once ready is seen, the controller runs one serial clock burst. The clock idles high and data changes on falling edges (clock polarity 1, phase 1). In that single burst the controller shifts a 14-bit configuration word out on `din` and captures the 16-bit result from `sdo_in`. When readback is selected it also captures the 14-bit configuration echo. The burst has 17 falling edges, or 31 when readback is selected, after which the converter releases its output. A timer limits the wait for ready; when it expires the controller sets an error flag and returns to idle.

The user side is a start / configuration / result handshake. Every request field is sampled only at the accepted start, and the results are registered outputs marked by a one-cycle `done` pulse.

Top module: `adc_busy_host`

## Requirements
- R1: After synchronous reset, `cnv`=0, `sck`=1, `din`=0, `busy`=0, `done`=0, `timeout_err`=0, `result`=0 and `cfg_readback`=0.
- R2: A `start` seen while idle raises `busy` on the next edge and drives `cnv` high for exactly CNV_HIGH_CYC clock cycles. `busy` is low in the cycle `done` is high.
- R3: After `cnv` falls, the first clock edge that samples `sdo_in` low is followed, SYNC_STAGES + CLK_DIV/2 edges later, by the first falling edge of `sck`.
- R4: `sck` idles high and holds each level for CLK_DIV/2 cycles during a burst. A burst has 17 falling edges when readback is off and 31 when it is on, and ends high. `done` is high for exactly one cycle, (2·edges − 1)·CLK_DIV/2 cycles after the first falling edge.
- R5: When `cfg_write_en` is high at the accepted start, the 14-bit `cfg_in` is sent MSB first. Each bit is set on a falling `sck` edge, so the first 14 rising edges capture the whole word. Otherwise `din` stays 0 for the whole burst.
- R6: `sdo_in` is sampled on the rising edge that follows each of the first 16 falling edges. The bits are assembled MSB first into `result`, which is valid when `done` is high.
- R7: With readback on, the samples after falling edges 17 to 30 form `cfg_readback` MSB first. With readback off, `cfg_readback` keeps its previous value.
- R8: If `sdo_in` is not seen low within TIMEOUT_CYC cycles after `cnv` falls, `timeout_err` sets and `busy` clears on that edge, with no `done` pulse, no `sck` edge and no change to `result`. The next accepted start clears `timeout_err`.
- R9: A `start` while `busy` is ignored: no second `cnv` pulse, and changes to `cfg_in`, `cfg_write_en` or `readback_en` after the accepted start do not alter the transfer.
- R10: `cnv` stays low while `sck` is low, and `din` is 0 while `cnv` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion and transfer |
| cfg_write_en | input | 1 | Send `cfg_in` during the burst |
| cfg_in | input | 14 | Configuration word to send |
| readback_en | input | 1 | Use the 31-edge burst and capture the configuration echo |
| sdo_in | input | 1 | Converter data output (pulled up when released) |
| cnv | output | 1 | Conversion-start line |
| sck | output | 1 | Serial clock, idles high |
| din | output | 1 | Serial data to the converter |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Ready wait expired |
| result | output | 16 | Last conversion result |
| cfg_readback | output | 14 | Last configuration echo |

## Verification
Every result has a fixed cycle count from an observable event. `busy` appears one edge after `start`. `cnv` is high for CNV_HIGH_CYC cycles. The first `sck` fall comes SYNC_STAGES + CLK_DIV/2 edges after SDO is first sampled low, and `done` follows (2·edges − 1)·CLK_DIV/2 cycles after that fall. On a timeout, `busy` clears exactly TIMEOUT_CYC edges after `cnv` falls. The bench keeps a cycle counter that ticks on rising edges and samples everything on falling clock edges. It timestamps the `cnv`, SDO and `sck` events and compares the differences with these formulas. Values are compared in the cycle `done` is seen.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CNV,
    ST_WAIT,
    ST_XFER
  } host_state_t;

  // number of falling serial-clock edges in one burst
  function automatic int unsigned burst_edges(input bit with_echo,
                                              input int unsigned res_w,
                                              input int unsigned cfg_w);
    return with_echo ? (res_w + cfg_w + 1) : (res_w + 1);
  endfunction

endpackage

// File: rtl/adc_bit_sync.sv
module adc_bit_sync #(
  parameter int unsigned STAGES   = 2,
  parameter bit          RST_LVL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= {STAGES{RST_LVL}};
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d};
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
  parameter int unsigned HALF  = 2,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic             sck,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic [CNT_W-1:0] fall_cnt
);

  localparam int unsigned DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);

  logic [DIV_W-1:0] div_q;
  logic             sck_q;
  logic [CNT_W-1:0] falls_q;
  logic             tick;

  assign tick     = run && (div_q == DIV_LAST);
  assign fall_stb = tick && sck_q;
  assign rise_stb = tick && !sck_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q   <= '0;
      sck_q   <= 1'b1;
      falls_q <= '0;
    end else begin
      if (tick) begin
        div_q <= '0;
        sck_q <= ~sck_q;
      end else begin
        div_q <= div_q + 1'b1;
      end
      if (fall_stb) begin
        falls_q <= falls_q + 1'b1;
      end
    end
  end

  assign sck      = sck_q;
  assign fall_cnt = falls_q;

endmodule

// File: rtl/adc_serdes.sv
module adc_serdes #(
  parameter int unsigned RES_W = 16,
  parameter int unsigned CFG_W = 14,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CFG_W-1:0] load_word,
  input  logic             fall_stb,
  input  logic             rise_stb,
  input  logic [CNT_W-1:0] fall_cnt,
  input  logic             sdo,
  output logic             din,
  output logic [RES_W-1:0] res_word,
  output logic [CFG_W-1:0] echo_word
);

  localparam logic [CNT_W-1:0] RES_END  = CNT_W'(RES_W);
  localparam logic [CNT_W-1:0] ECHO_END = CNT_W'(RES_W + CFG_W);

  logic [CFG_W-1:0] tx_q;
  logic             din_q;
  logic [RES_W-1:0] res_q;
  logic [CFG_W-1:0] echo_q;
  logic             in_res;
  logic             in_echo;

  assign in_res  = (fall_cnt != '0) && (fall_cnt <= RES_END);
  assign in_echo = (fall_cnt > RES_END) && (fall_cnt <= ECHO_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      din_q  <= 1'b0;
      res_q  <= '0;
      echo_q <= '0;
    end else if (load) begin
      tx_q  <= load_word;
      din_q <= 1'b0;
    end else begin
      if (fall_stb) begin
        din_q <= tx_q[CFG_W-1];
        tx_q  <= {tx_q[CFG_W-2:0], 1'b0};
      end
      if (rise_stb && in_res) begin
        res_q <= {res_q[RES_W-2:0], sdo};
      end
      if (rise_stb && in_echo) begin
        echo_q <= {echo_q[CFG_W-2:0], sdo};
      end
    end
  end

  assign din       = din_q;
  assign res_word  = res_q;
  assign echo_word = echo_q;

endmodule

// File: rtl/adc_busy_host.sv
module adc_busy_host
  import adc_host_pkg::*;
#(
  parameter int unsigned CLK_DIV      = 4,
  parameter int unsigned RES_W        = 16,
  parameter int unsigned CFG_W        = 14,
  parameter int unsigned CNV_HIGH_CYC = 3,
  parameter int unsigned TIMEOUT_CYC  = 1000,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cfg_write_en,
  input  logic [CFG_W-1:0] cfg_in,
  input  logic             readback_en,
  input  logic             sdo_in,
  output logic             cnv,
  output logic             sck,
  output logic             din,
  output logic             busy,
  output logic             done,
  output logic             timeout_err,
  output logic [RES_W-1:0] result,
  output logic [CFG_W-1:0] cfg_readback
);

  localparam int unsigned HALF      = CLK_DIV / 2;
  localparam int unsigned LEN_LONG  = burst_edges(1'b1, RES_W, CFG_W);
  localparam int unsigned LEN_SHORT = burst_edges(1'b0, RES_W, CFG_W);
  localparam int unsigned CNT_W     = $clog2(LEN_LONG + 1);
  localparam int unsigned TMR_MAX   = (CNV_HIGH_CYC > TIMEOUT_CYC) ? CNV_HIGH_CYC : TIMEOUT_CYC;
  localparam int unsigned TMR_W     = $clog2(TMR_MAX + 1);

  host_state_t      state_q;
  logic [TMR_W-1:0] tmr_q;
  logic             echo_sel_q;
  logic             cnv_q;
  logic             busy_q;
  logic             done_q;
  logic             err_q;
  logic [RES_W-1:0] result_q;
  logic [CFG_W-1:0] echo_q;

  logic             sck_run;
  logic             fall_stb;
  logic             rise_stb;
  logic [CNT_W-1:0] fall_cnt;
  logic             sdo_sync;
  logic             data_rdy;
  logic [CNT_W-1:0] burst_len;
  logic             last_rise;
  logic             load_tx;
  logic [CFG_W-1:0] tx_word;
  logic [RES_W-1:0] res_word;
  logic [CFG_W-1:0] echo_word;

  assign sck_run   = (state_q == ST_XFER);
  assign burst_len = echo_sel_q ? CNT_W'(LEN_LONG) : CNT_W'(LEN_SHORT);
  assign last_rise = rise_stb && (fall_cnt == burst_len);
  assign load_tx   = (state_q == ST_IDLE) && start;
  assign tx_word   = cfg_write_en ? cfg_in : '0;
  assign data_rdy  = ~sdo_sync;

  adc_bit_sync #(
    .STAGES (SYNC_STAGES),
    .RST_LVL(1'b1)
  ) u_rdy_sync (
    .clk(clk),
    .rst(rst),
    .d  (sdo_in),
    .q  (sdo_sync)
  );

  adc_sck_gen #(
    .HALF (HALF),
    .CNT_W(CNT_W)
  ) u_sck_gen (
    .clk     (clk),
    .rst     (rst),
    .run     (sck_run),
    .sck     (sck),
    .fall_stb(fall_stb),
    .rise_stb(rise_stb),
    .fall_cnt(fall_cnt)
  );

  adc_serdes #(
    .RES_W(RES_W),
    .CFG_W(CFG_W),
    .CNT_W(CNT_W)
  ) u_serdes (
    .clk      (clk),
    .rst      (rst),
    .load     (load_tx),
    .load_word(tx_word),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb),
    .fall_cnt (fall_cnt),
    .sdo      (sdo_in),
    .din      (din),
    .res_word (res_word),
    .echo_word(echo_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      tmr_q      <= '0;
      echo_sel_q <= 1'b0;
      cnv_q      <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      result_q   <= '0;
      echo_q     <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q    <= ST_CNV;
            cnv_q      <= 1'b1;
            busy_q     <= 1'b1;
            err_q      <= 1'b0;
            echo_sel_q <= readback_en;
            tmr_q      <= TMR_W'(CNV_HIGH_CYC - 1);
          end
        end
        ST_CNV: begin
          if (tmr_q == '0) begin
            cnv_q   <= 1'b0;
            state_q <= ST_WAIT;
            tmr_q   <= TMR_W'(TIMEOUT_CYC - 1);
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ST_WAIT: begin
          if (data_rdy) begin
            state_q <= ST_XFER;
          end else if (tmr_q == '0) begin
            err_q   <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ST_XFER: begin
          if (last_rise) begin
            state_q  <= ST_IDLE;
            busy_q   <= 1'b0;
            done_q   <= 1'b1;
            result_q <= res_word;
            if (echo_sel_q) begin
              echo_q <= echo_word;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv          = cnv_q;
  assign busy         = busy_q;
  assign done         = done_q;
  assign timeout_err  = err_q;
  assign result       = result_q;
  assign cfg_readback = echo_q;

endmodule

// File: rtl/adc_busy_host_chk.sv
module adc_busy_host_chk #(
  parameter int unsigned HALF = 2
) (
  input logic clk,
  input logic rst,
  input logic cnv,
  input logic sck,
  input logic din,
  input logic busy,
  input logic done,
  input logic timeout_err
);

  logic [15:0] low_len;

  always_ff @(posedge clk) begin
    if (rst || sck) begin
      low_len <= '0;
    end else if (low_len != 16'hFFFF) begin
      low_len <= low_len + 1'b1;
    end
  end

  // R4: serial clock rests high whenever no request is active
  p_sck_idle_r4: assert property (@(posedge clk) disable iff (rst) !busy |-> sck);

  // R4: completion is a single-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R4: every low phase of the serial clock lasts HALF cycles
  p_sck_low_len_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sck) |-> (low_len == 16'(HALF)));

  // R2: busy is released when the completion pulse appears
  p_busy_done_r2: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

  // R2: a conversion pulse only starts inside an active request
  p_cnv_busy_r2: assert property (@(posedge clk) disable iff (rst) $rose(cnv) |-> busy);

  // R8: a timed-out request never completes
  p_err_no_done_r8: assert property (@(posedge clk) disable iff (rst) timeout_err |-> !done);

  // R10: conversion start stays low during the clock burst
  p_cnv_low_burst_r10: assert property (@(posedge clk) disable iff (rst) !sck |-> !cnv);

  // R10: data-in quiet while the conversion start is high
  p_din_quiet_r10: assert property (@(posedge clk) disable iff (rst) cnv |-> !din);

endmodule

bind adc_busy_host adc_busy_host_chk #(
  .HALF(CLK_DIV / 2)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cnv        (cnv),
  .sck        (sck),
  .din        (din),
  .busy       (busy),
  .done       (done),
  .timeout_err(timeout_err)
);

// File: tb/test_adc_busy_host.sv
module test_adc_busy_host;

  localparam int CLK_PERIOD  = 10;
  localparam int CLK_DIV     = 4;
  localparam int HALF        = CLK_DIV / 2;
  localparam int CNV_HIGH    = 3;
  localparam int TIMEOUT     = 40;
  localparam int SYNC        = 2;

  logic        clk;
  logic        rst;
  logic        start;
  logic        cfg_write_en;
  logic [13:0] cfg_in;
  logic        readback_en;
  logic        sdo_in;
  logic        cnv, sck, din, busy, done, timeout_err;
  logic [15:0] result;
  logic [13:0] cfg_readback;

  adc_busy_host #(
    .CLK_DIV     (CLK_DIV),
    .RES_W       (16),
    .CFG_W       (14),
    .CNV_HIGH_CYC(CNV_HIGH),
    .TIMEOUT_CYC (TIMEOUT),
    .SYNC_STAGES (SYNC)
  ) i_adc_busy_host (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .cfg_write_en(cfg_write_en),
    .cfg_in      (cfg_in),
    .readback_en (readback_en),
    .sdo_in      (sdo_in),
    .cnv         (cnv),
    .sck         (sck),
    .din         (din),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .result      (result),
    .cfg_readback(cfg_readback)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  // converter model state
  bit          respond = 1'b1;
  int          conv_lat = 2;
  logic [15:0] m_res = '0;
  logic [13:0] m_echo = '0;
  bit          m_echo_on = 1'b0;
  int          fall_k = 0;
  int          rise_k = 0;
  logic [13:0] cap = '0;
  int          cnv_rises = 0;
  int          t_low = 0;
  int          t_fall = 0;
  int          t_cnv_rise = 0;
  int          t_cnv_fall = 0;
  bit          fall_seen = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
    $finish;
  end

  // converter model: new conversion
  initial begin
    sdo_in = 1'b1;
    forever begin
      @(posedge cnv);
      cnv_rises++;
      sdo_in    = 1'b1;
      fall_k    = 0;
      rise_k    = 0;
      cap       = '0;
      fall_seen = 1'b0;
    end
  end

  // converter model: ready indication after cnv falls
  initial forever begin
    @(negedge cnv);
    if (respond) begin
      repeat (conv_lat) @(negedge clk);
      if (!cnv) begin
        sdo_in = 1'b0;
        t_low  = cyc;
      end
    end
  end

  // converter model: output bits on falling serial clock
  initial forever begin
    @(negedge sck);
    @(negedge clk);
    fall_k++;
    if (fall_k <= 16) sdo_in = m_res[16 - fall_k];
    else if (m_echo_on && fall_k <= 30) sdo_in = m_echo[30 - fall_k];
    else sdo_in = 1'b1;
  end

  // converter model: capture configuration on rising serial clock
  initial forever begin
    @(posedge sck);
    rise_k++;
    if (rise_k <= 14) cap = {cap[12:0], din};
  end

  // timestamp monitor
  initial begin
    logic cnv_p, sck_p;
    cnv_p = 1'b0;
    sck_p = 1'b1;
    forever begin
      @(negedge clk);
      if (cnv === 1'b1 && cnv_p === 1'b0) t_cnv_rise = cyc;
      if (cnv === 1'b0 && cnv_p === 1'b1) t_cnv_fall = cyc;
      if (sck === 1'b0 && sck_p === 1'b1 && !fall_seen) begin
        t_fall    = cyc;
        fall_seen = 1'b1;
      end
      cnv_p = cnv;
      sck_p = sck;
    end
  end

  logic [13:0] exp_echo = '0;
  logic [15:0] last_res = '0;

  task automatic run_trial(input bit wr, input bit rb, input logic [15:0] res,
                           input logic [13:0] cfg, input logic [13:0] echo, input int lat);
    int rises0;
    int edges;
    bit got;
    m_res     = res;
    m_echo    = echo;
    m_echo_on = rb;
    conv_lat  = lat;
    respond   = 1'b1;
    rises0    = cnv_rises;
    edges     = rb ? 31 : 17;
    @(negedge clk);
    start = 1'b1; cfg_in = cfg; cfg_write_en = wr; readback_en = rb;
    @(negedge clk);
    start = 1'b0; cfg_in = ~cfg; cfg_write_en = !wr; readback_en = !rb;
    chk(busy === 1'b1, "R2", "busy after start", busy, 1);
    repeat (1) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 800; k++) begin
      @(negedge clk);
      if (done === 1'b1) begin
        got = 1'b1;
        break;
      end
    end
    chk(got, "R4", "done seen", got, 1);
    chk(t_cnv_fall - t_cnv_rise == CNV_HIGH, "R2", "cnv width", t_cnv_fall - t_cnv_rise, CNV_HIGH);
    chk(busy === 1'b0, "R2", "busy at done", busy, 0);
    chk(t_fall - t_low == SYNC + HALF + 1, "R3", "ready to first fall", t_fall - t_low, SYNC + HALF + 1);
    chk(cyc - t_fall == (2 * edges - 1) * HALF, "R4", "first fall to done", cyc - t_fall,
        (2 * edges - 1) * HALF);
    chk(fall_k == edges, "R4", "falling edge count", fall_k, edges);
    chk(result === res, "R6", "result", result, res);
    if (rb) exp_echo = echo;
    chk(cfg_readback === exp_echo, "R7", "cfg readback", cfg_readback, exp_echo);
    chk(cap === (wr ? cfg : 14'h0), "R5", "captured din word", cap, wr ? cfg : 14'h0);
    chk(cnv_rises - rises0 == 1, "R9", "cnv pulses per request", cnv_rises - rises0, 1);
    chk(timeout_err === 1'b0, "R8", "no error on good transfer", timeout_err, 0);
    last_res = res;
    @(negedge clk);
    chk(done === 1'b0, "R4", "done one cycle", done, 0);
    chk(sck === 1'b1, "R4", "sck high after burst", sck, 1);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; cfg_write_en = 1'b0; cfg_in = '0; readback_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(cnv === 1'b0, "R1", "cnv in reset", cnv, 0);
    chk(sck === 1'b1, "R1", "sck in reset", sck, 1);
    chk(din === 1'b0, "R1", "din in reset", din, 0);
    chk(busy === 1'b0 && done === 1'b0 && timeout_err === 1'b0, "R1", "status in reset",
        {busy, done, timeout_err}, 0);
    chk(result === 16'h0 && cfg_readback === 14'h0, "R1", "data in reset",
        {result, 2'b00, cfg_readback}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int rb = 0; rb < 2; rb++) begin
      for (int wr = 0; wr < 2; wr++) begin
        for (int p = 0; p < 6; p++) begin
          logic [15:0] res;
          logic [13:0] cfg;
          res = (p == 0) ? 16'h0000 : (p == 1) ? 16'hFFFF :
                16'((p * 40503) ^ (p << 13) ^ (rb * 16'h0101) ^ (wr * 16'h1010));
          cfg = 14'((p * 1237 + rb * 3 + wr * 5) ^ 14'h2AAA);
          if (p == 1) cfg = 14'h3FFF;
          run_trial(wr[0], rb[0], res, cfg, 14'(~cfg ^ 14'(p)), 2 + p % 3);
        end
      end
    end

    // timeout: converter never signals ready (R8)
    begin
      int f0;
      respond = 1'b0;
      f0 = fall_k;
      @(negedge clk);
      start = 1'b1; cfg_in = 14'h1234; cfg_write_en = 1'b1; readback_en = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 50 && cnv !== 1'b0; k++) @(negedge clk);
      repeat (TIMEOUT - 1) @(negedge clk);
      chk(busy === 1'b1 && timeout_err === 1'b0, "R8", "still waiting before limit",
          {busy, timeout_err}, 2'b10);
      @(negedge clk);
      chk(busy === 1'b0 && timeout_err === 1'b1, "R8", "timeout at limit",
          {busy, timeout_err}, 2'b01);
      chk(done === 1'b0, "R8", "no done on timeout", done, 0);
      chk(fall_k == 0 && sck === 1'b1, "R8", "no sck edges on timeout", fall_k, 0);
      chk(result === last_res, "R8", "result kept on timeout", result, last_res);
      repeat (3) @(negedge clk);
      chk(timeout_err === 1'b1, "R8", "error flag holds", timeout_err, 1);
      respond = 1'b1;
      @(negedge clk);
      start = 1'b1; cfg_in = 14'h0F0F; cfg_write_en = 1'b1; readback_en = 1'b0;
      @(negedge clk);
      start = 1'b0;
      chk(timeout_err === 1'b0, "R8", "error cleared by start", timeout_err, 0);
      for (int k = 0; k < 400 && done !== 1'b1; k++) @(negedge clk);
      repeat (2) @(negedge clk);
    end

    run_trial(1'b1, 1'b1, 16'hA5C3, 14'h2DB6, 14'h1249, 3);

    report();
    $finish;
  end

endmodule